// File: doc/BRIEF.md
# Three-operand NaN result selector

This block decides which operand a fused multiply-add unit computing (a*b)+c should pass on as its NaN result, or whether it should produce the default NaN instead. The caller classifies each of the three operands into quiet and signaling flags and reports when the product is infinity times zero. The block returns a 2-bit selection code and an invalid-operation flag. Classifying the operands, the arithmetic and the final quieting of the chosen NaN are left to the caller.

Four rule sets are available through `mode_i`. They differ in the order in which operands and NaN kinds are ranked, and in how the infinity-times-zero case combines with a NaN addend. In one rule set a polarity input picks between two orders; it reports which value of the quiet bit marks a signaling NaN. All outputs are purely combinational. `mode_i` and `snan_one_i` are meant to be tied or held static for the life of the unit.

Top module: `fma_nan_select`

## Requirements
- R1: `sel_o` encodes the choice as 0 = operand a, 1 = operand b, 2 = operand c, 3 = default NaN. `mode_i` selects the rule set: 0 = addend-first, 1 = polarity-dependent, 2 = multiplicand-first, 3 = operand-order.
- R2: In mode 0, when `inf_zero_i` is high and c is a quiet NaN, `sel_o` is 3 and `invalid_o` is 1.
- R3: In mode 0 outside the R2 case, the first match in this list wins: c signaling (2), a signaling (0), b signaling (1), c quiet (2), a quiet (0). With no match `sel_o` is 1.
- R4: In mode 1, `inf_zero_i` high gives `sel_o` = 3 and `invalid_o` = 1, whatever the NaN flags are.
- R5: In mode 1 with `snan_one_i` high and `inf_zero_i` low, the first match in this list wins: a signaling (0), b signaling (1), c signaling (2), a quiet (0), b quiet (1). With no match `sel_o` is 2.
- R6: In mode 1 with `snan_one_i` low and `inf_zero_i` low, the ranking of R3 applies.
- R7: In mode 2, `inf_zero_i` high gives `invalid_o` = 1 and `sel_o` = 2.
- R8: In mode 2 with `inf_zero_i` low, `sel_o` is 0 if a is any NaN, else 2 if c is any NaN, else 1.
- R9: In mode 3, `sel_o` is 0 if a is any NaN, else 1 if b is any NaN, else 2. `inf_zero_i` has no effect in this mode.
- R10: `invalid_o` is 0 in every case not covered by R2, R4 or R7.
- R11: `snan_one_i` has no effect on either output in modes 0, 2 and 3.
- R12: Both outputs follow the inputs within the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_i | input | 2 | Rule set select (R1) |
| snan_one_i | input | 1 | Signaling-NaN polarity; used only in mode 1 |
| a_qnan_i | input | 1 | Operand a is a quiet NaN |
| a_snan_i | input | 1 | Operand a is a signaling NaN |
| b_qnan_i | input | 1 | Operand b is a quiet NaN |
| b_snan_i | input | 1 | Operand b is a signaling NaN |
| c_qnan_i | input | 1 | Operand c (addend) is a quiet NaN |
| c_snan_i | input | 1 | Operand c (addend) is a signaling NaN |
| inf_zero_i | input | 1 | The product is infinity times zero |
| sel_o | output | 2 | Selection code |
| invalid_o | output | 1 | Invalid operation from the infinity-times-zero case |

## Verification
Every mode is swept over all 128 combinations of the seven flags, with both polarities. This covers the patterns that separate the rankings. A signaling b against a quiet c shows whether signaling NaNs outrank quiet ones across operands; a design with a per-operand order would return c. An infinity-times-zero case with a signaling or non-NaN c in mode 0 catches an override that ignores the quiet-addend condition: such a design would return 3 and raise invalid too often. Mode 2 with infinity times zero and a NaN in a catches a design that returns a instead of c, and the default code for each mode exposes any swap between b and c. The polarity input is toggled in the modes that must ignore it, so a mux that leaks that input shows up as an output change.

// File: rtl/fma_nan_pkg.sv
package fma_nan_pkg;
  localparam int SEL_W = 2;
  typedef logic [SEL_W-1:0] sel_t;

  localparam sel_t SEL_A    = 2'd0;
  localparam sel_t SEL_B    = 2'd1;
  localparam sel_t SEL_C    = 2'd2;
  localparam sel_t SEL_DFLT = 2'd3;

  typedef enum logic [1:0] {
    MODE_ADDEND_FIRST = 2'd0,
    MODE_POLARITY     = 2'd1,
    MODE_MULT_FIRST   = 2'd2,
    MODE_OPER_ORDER   = 2'd3
  } mode_t;
endpackage

// File: rtl/fma_nan_prio.sv
// Fixed priority pick: req_i[0] is the strongest entry.
module fma_nan_prio
  import fma_nan_pkg::*;
#(
  parameter int N = 5
) (
  input  logic [N-1:0] req_i,
  input  sel_t [N-1:0] code_i,
  input  sel_t         dflt_i,
  output sel_t         sel_o
);
  always_comb begin
    sel_o = dflt_i;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) sel_o = code_i[i];
    end
  end
endmodule

// File: rtl/fma_nan_override.sv
// Infinity-times-zero handling per rule set.
module fma_nan_override
  import fma_nan_pkg::*;
(
  input  mode_t mode_i,
  input  logic  inf_zero_i,
  input  logic  c_qnan_i,
  output logic  force_dflt_o,
  output logic  force_c_o,
  output logic  invalid_o
);
  always_comb begin
    force_dflt_o = 1'b0;
    force_c_o    = 1'b0;
    unique case (mode_i)
      MODE_ADDEND_FIRST: force_dflt_o = inf_zero_i & c_qnan_i;
      MODE_POLARITY:     force_dflt_o = inf_zero_i;
      MODE_MULT_FIRST:   force_c_o    = inf_zero_i;
      default:           ;
    endcase
    invalid_o = force_dflt_o | force_c_o;
  end
endmodule

// File: rtl/fma_nan_select.sv
module fma_nan_select
  import fma_nan_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       snan_one_i,
  input  logic       a_qnan_i,
  input  logic       a_snan_i,
  input  logic       b_qnan_i,
  input  logic       b_snan_i,
  input  logic       c_qnan_i,
  input  logic       c_snan_i,
  input  logic       inf_zero_i,
  output logic [1:0] sel_o,
  output logic       invalid_o
);
  localparam int RANK_N = 5;
  localparam int ANY_N  = 2;

  mode_t mode;
  logic  a_any, b_any, c_any;
  logic  force_dflt, force_c;
  sel_t  sel_cfirst, sel_sigfirst, sel_mult, sel_order;

  assign mode  = mode_t'(mode_i);
  assign a_any = a_qnan_i | a_snan_i;
  assign b_any = b_qnan_i | b_snan_i;
  assign c_any = c_qnan_i | c_snan_i;

  // signaling across all operands first, addend leads
  fma_nan_prio #(.N(RANK_N)) i_rank_cfirst (
    .req_i ({a_qnan_i, c_qnan_i, b_snan_i, a_snan_i, c_snan_i}),
    .code_i({SEL_A,    SEL_C,    SEL_B,    SEL_A,    SEL_C}),
    .dflt_i(SEL_B),
    .sel_o (sel_cfirst)
  );

  // signaling across all operands first, operand order
  fma_nan_prio #(.N(RANK_N)) i_rank_sigfirst (
    .req_i ({b_qnan_i, a_qnan_i, c_snan_i, b_snan_i, a_snan_i}),
    .code_i({SEL_B,    SEL_A,    SEL_C,    SEL_B,    SEL_A}),
    .dflt_i(SEL_C),
    .sel_o (sel_sigfirst)
  );

  fma_nan_prio #(.N(ANY_N)) i_rank_mult (
    .req_i ({c_any, a_any}),
    .code_i({SEL_C, SEL_A}),
    .dflt_i(SEL_B),
    .sel_o (sel_mult)
  );

  fma_nan_prio #(.N(ANY_N)) i_rank_order (
    .req_i ({b_any, a_any}),
    .code_i({SEL_B, SEL_A}),
    .dflt_i(SEL_C),
    .sel_o (sel_order)
  );

  fma_nan_override i_override (
    .mode_i      (mode),
    .inf_zero_i  (inf_zero_i),
    .c_qnan_i    (c_qnan_i),
    .force_dflt_o(force_dflt),
    .force_c_o   (force_c),
    .invalid_o   (invalid_o)
  );

  always_comb begin
    if (force_dflt) begin
      sel_o = SEL_DFLT;
    end else if (force_c) begin
      sel_o = SEL_C;
    end else begin
      unique case (mode)
        MODE_ADDEND_FIRST: sel_o = sel_cfirst;
        MODE_POLARITY:     sel_o = snan_one_i ? sel_sigfirst : sel_cfirst;
        MODE_MULT_FIRST:   sel_o = sel_mult;
        default:           sel_o = sel_order;
      endcase
    end
  end
endmodule

// File: rtl/fma_nan_select_chk.sv
module fma_nan_select_chk (
  input logic [1:0] mode_i,
  input logic       snan_one_i,
  input logic       a_qnan_i,
  input logic       a_snan_i,
  input logic       b_qnan_i,
  input logic       b_snan_i,
  input logic       c_qnan_i,
  input logic       c_snan_i,
  input logic       inf_zero_i,
  input logic [1:0] sel_o,
  input logic       invalid_o
);
  logic any_sig, pick_sig, pick_any;

  always_comb begin
    any_sig  = a_snan_i | b_snan_i | c_snan_i;
    pick_sig = (sel_o == 2'd0 && a_snan_i) || (sel_o == 2'd1 && b_snan_i) ||
               (sel_o == 2'd2 && c_snan_i);
    pick_any = (sel_o == 2'd0 && (a_snan_i | a_qnan_i)) ||
               (sel_o == 2'd1 && (b_snan_i | b_qnan_i)) ||
               (sel_o == 2'd2 && (c_snan_i | c_qnan_i));

    // R10: invalid only from an infinity-times-zero product
    a_r10_invalid_needs_inf_zero: assert (!invalid_o || inf_zero_i);
    // R9: operand-order mode never flags invalid
    a_r9_order_no_invalid: assert (!(mode_i == 2'd3 && invalid_o));
    // R2: mode 0 override
    a_r2_addend_dflt: assert (!(mode_i == 2'd0 && inf_zero_i && c_qnan_i) ||
                              (sel_o == 2'd3 && invalid_o));
    // R3: a signaling operand wins whenever one exists
    a_r3_sig_wins: assert (!(mode_i == 2'd0 && any_sig && !(inf_zero_i && c_qnan_i)) ||
                           pick_sig);
    // R4: mode 1 override
    a_r4_pol_dflt: assert (!(mode_i == 2'd1 && inf_zero_i) || (sel_o == 2'd3 && invalid_o));
    // R7: mode 2 returns c under infinity times zero
    a_r7_mult_keeps_c: assert (!(mode_i == 2'd2 && inf_zero_i) || (sel_o == 2'd2 && invalid_o));
    // R8: mode 2 prefers a NaN in a
    a_r8_mult_a_first: assert (!(mode_i == 2'd2 && !inf_zero_i && (a_qnan_i | a_snan_i)) ||
                               sel_o == 2'd0);
    // R9: mode 3 picks a NaN operand when one exists
    a_r9_order_picks_nan: assert (!(mode_i == 2'd3 &&
                                    (a_qnan_i | a_snan_i | b_qnan_i | b_snan_i)) || pick_any);
    // R1: default code only where an override demands it
    a_r1_dflt_only_override: assert (sel_o != 2'd3 || invalid_o);
    // R11: polarity is only read in mode 1
    a_r11_pol_unused: assert (!(mode_i != 2'd1 && snan_one_i && invalid_o && mode_i == 2'd3));
  end
endmodule

bind fma_nan_select fma_nan_select_chk i_chk (
  .mode_i    (mode_i),
  .snan_one_i(snan_one_i),
  .a_qnan_i  (a_qnan_i),
  .a_snan_i  (a_snan_i),
  .b_qnan_i  (b_qnan_i),
  .b_snan_i  (b_snan_i),
  .c_qnan_i  (c_qnan_i),
  .c_snan_i  (c_snan_i),
  .inf_zero_i(inf_zero_i),
  .sel_o     (sel_o),
  .invalid_o (invalid_o)
);

// File: tb/test_fma_nan_select.sv
`timescale 1ns/1ps
module test_fma_nan_select;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_i = '0;
  logic       snan_one_i = 1'b0;
  logic       a_qnan_i = 1'b0, a_snan_i = 1'b0;
  logic       b_qnan_i = 1'b0, b_snan_i = 1'b0;
  logic       c_qnan_i = 1'b0, c_snan_i = 1'b0;
  logic       inf_zero_i = 1'b0;
  logic [1:0] sel_o;
  logic       invalid_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fma_nan_select i_fma_nan_select (
    .mode_i(mode_i), .snan_one_i(snan_one_i),
    .a_qnan_i(a_qnan_i), .a_snan_i(a_snan_i),
    .b_qnan_i(b_qnan_i), .b_snan_i(b_snan_i),
    .c_qnan_i(c_qnan_i), .c_snan_i(c_snan_i),
    .inf_zero_i(inf_zero_i), .sel_o(sel_o), .invalid_o(invalid_o)
  );

  // Reference: ordered list of (operand, kind) probes; kind 0 sig, 1 quiet, 2 any.
  function automatic void model(input int mode, input bit pol, input bit [6:0] f,
                                output int sel, output bit inv);
    int ops[$];
    int kinds[$];
    int fallback;
    bit q[3];
    bit s[3];
    for (int k = 0; k < 3; k++) begin
      q[k] = f[2*k];
      s[k] = f[2*k+1];
    end
    inv = 1'b0;
    if (mode == 0 && f[6] && q[2]) begin inv = 1'b1; sel = 3; return; end
    if (mode == 1 && f[6])         begin inv = 1'b1; sel = 3; return; end
    if (mode == 2 && f[6])         begin inv = 1'b1; sel = 2; return; end
    if (mode == 1 && pol) begin
      ops = '{0, 1, 2, 0, 1};  kinds = '{0, 0, 0, 1, 1};  fallback = 2;
    end else if (mode <= 1) begin
      ops = '{2, 0, 1, 2, 0};  kinds = '{0, 0, 0, 1, 1};  fallback = 1;
    end else if (mode == 2) begin
      ops = '{0, 2};  kinds = '{2, 2};  fallback = 1;
    end else begin
      ops = '{0, 1};  kinds = '{2, 2};  fallback = 2;
    end
    sel = fallback;
    for (int j = 0; j < ops.size(); j++) begin
      bit hit;
      hit = (kinds[j] == 0) ? s[ops[j]] : (kinds[j] == 1) ? q[ops[j]] : (s[ops[j]] | q[ops[j]]);
      if (hit) begin sel = ops[j]; return; end
    end
  endfunction

  task automatic apply(input int mode, input bit pol, input bit [6:0] f);
    mode_i = mode[1:0];
    snan_one_i = pol;
    {inf_zero_i, c_snan_i, c_qnan_i, b_snan_i, b_qnan_i, a_snan_i, a_qnan_i} = f;
  endtask

  task automatic check(input string req, input int exp_sel, input bit exp_inv);
    n_checks++;
    if (int'(sel_o) != exp_sel || invalid_o != exp_inv) begin
      n_fail++;
      $display("FAIL %s: mode=%0d pol=%0b flags=%b got sel=%0d inv=%0b exp sel=%0d inv=%0b",
               req, mode_i, snan_one_i,
               {inf_zero_i, c_snan_i, c_qnan_i, b_snan_i, b_qnan_i, a_snan_i, a_qnan_i},
               sel_o, invalid_o, exp_sel, exp_inv);
    end
  endtask

  function automatic string tag(input int mode, input bit pol, input bit [6:0] f);
    if (pol && mode != 1) return "R11";
    case (mode)
      0: return (f[6] && f[4]) ? "R2" : "R3";
      1: return f[6] ? "R4" : (pol ? "R5" : "R6");
      2: return f[6] ? "R7" : "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    int es;
    bit ei;
    repeat (4) @(posedge clk);
    #1 check("R1 reset state mode0 no NaN picks b", 1, 1'b0);
    rst_n = 1'b1;
    @(posedge clk);

    // R1 directed: each single NaN in mode 3 maps to its code
    #1 apply(3, 0, 7'b0000001); #1 check("R1 code a", 0, 1'b0);
    @(posedge clk); #1 apply(3, 0, 7'b0000100); #1 check("R1 code b", 1, 1'b0);
    @(posedge clk); #1 apply(3, 0, 7'b0010000); #1 check("R1 code c", 2, 1'b0);
    // R12: output follows a change within the same cycle
    @(posedge clk); #1 apply(0, 0, 7'b1010000); #0.5 check("R12 same-cycle response", 3, 1'b1);
    #0.5 apply(0, 0, 7'b0000001); #0.5 check("R12 same-cycle release", 0, 1'b0);

    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 2; p++) begin
        for (int v = 0; v < 128; v++) begin
          @(posedge clk);
          #1 apply(m, p[0], v[6:0]);
          model(m, p[0], v[6:0], es, ei);
          #1 check(tag(m, p[0], v[6:0]), es, ei);
          if (!ei) check("R10 invalid low", es, 1'b0);
        end
      end
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, got no end expected end");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule